// File: doc/BRIEF.md
# Tolerance-Adjusted Threshold Code Generator

This block turns a user threshold given in millivolts into the raw 12-bit code that an analog-to-digital converter's window comparator is programmed with. It first maps the millivolt value back to a converter code through the channel's gain. For a trimmed channel it then undoes the trim, using the per-mille gain correction and the offset. Last, it moves the code outward by the worst-case integral nonlinearity, gain error and offset error. The direction of that move follows the trigger, so a rising trip point is never set too early and a falling trip point is never set too late.

The caller places the threshold, the direction, a calibrated flag and the channel's gain, gain correction and offset on the inputs, then pulses `start_i`. The inputs are sampled only in that cycle. The block uses one serial divider for each of its divisions in turn, returns the code with a one-cycle `done_o` strobe, and holds the result until the next completed request. A request whose threshold lies outside the code range, or whose gain is not positive, is refused at once. The calibration data itself is kept elsewhere.

Top module: `thr_code_gen`

## Requirements
- R1: After reset, `code_o` is 0, `done_o` is 0 and `rejected_o` is 0.
- R2: The first step forms the base code as (thr_mv_i·1000)/gain_i.
- R3: When `calibrated_i` is 1, the base code c is replaced by (c·kerr_i + offset_i)/1000 for a rising request and by (c·kerr_i − offset_i)/1000 for a falling request. `rising_i` = 1 selects rising.
- R4: A calibrated rising request produces ((c+2)·(1000+2))/1000 + 2.
- R5: A calibrated falling request produces ((c−2)·(1000−6))/1000 − 2.
- R6: When `calibrated_i` is 0, the step in R3 is skipped. Rising then uses +2, +22 and +36, and falling uses −2, −26 and −36, for the nonlinearity, the gain error and the offset error respectively.
- R7: Every division is signed and truncates toward zero.
- R8: The delivered code saturates to the range 0..4095.
- R9: A request with thr_mv_i below 0 or above 4095, or with gain_i ≤ 0, raises `done_o` together with `rejected_o` = 1 in the cycle after `start_i` and leaves `code_o` unchanged.
- R10: `done_o` rises only in answer to an accepted request, no later than 3·(DW+2)+2 cycles after it. `code_o` and `rejected_o` change only in a cycle in which `done_o` is high. An accepted valid request drops `rejected_o` to 0.
- R11: A `start_i` that arrives while a valid request is still being computed is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe; the other inputs are sampled with it |
| rising_i | input | 1 | 1 = rising trigger, 0 = falling trigger |
| calibrated_i | input | 1 | 1 = the channel has trim data |
| thr_mv_i | input | THR_W (16) | Signed threshold in millivolts |
| gain_i | input | GAIN_W (16) | Signed channel gain, millivolt per code ×1000 |
| kerr_i | input | KERR_W (16) | Signed gain correction in per mille (about 1000) |
| offset_i | input | OFF_W (32) | Signed trim offset, codes ×1000 |
| done_o | output | 1 | One-cycle completion strobe |
| rejected_o | output | 1 | Last completed request was refused |
| code_o | output | CODE_W (12) | Comparator code |

## Verification
The main function is driven with trimmed and untrimmed channels in both directions, using values chosen so that each tolerance set gives a different code. This exposes a swapped sign or a wrong margin. One trimmed rising case has a negative intermediate quotient, where truncation toward zero and flooring give codes that differ by one. Other cases push the result past 4095 and below 0, which shows whether the saturation acts on the full-width value. Refused requests and a second start issued while a request is in flight are checked to show that neither disturbs the held code.

// File: rtl/thr_code_pkg.sv
package thr_code_pkg;

   // Sequencer phases: base-code division, trim undo, tolerance widening
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_INV  = 2'd1,
      ST_CAL  = 2'd2,
      ST_TOL  = 2'd3
   } thr_state_e;

   // Fixed-point scale of gains, corrections and tolerances (per mille)
   localparam int PER_MILLE = 1000;

endpackage

// File: rtl/thr_tol_pick.sv
// Selects the signed worst-case margins for one request.
module thr_tol_pick #(
   parameter int DW       = 48,
   parameter int INL_LSB  = 2,
   parameter int GE_RISE  = 2,
   parameter int GE_FALL  = 6,
   parameter int GE_UNCAL = 20,
   parameter int OE_CAL   = 2,
   parameter int OE_UNCAL = 36
) (
   input  logic                 rising_i,
   input  logic                 cal_i,
   output logic signed [DW-1:0] inl_o,
   output logic signed [DW-1:0] gerr_o,
   output logic signed [DW-1:0] oerr_o
);

   localparam logic signed [DW-1:0] INL_X    = DW'(INL_LSB);
   localparam logic signed [DW-1:0] GE_R_X   = DW'(GE_RISE);
   localparam logic signed [DW-1:0] GE_F_X   = DW'(GE_FALL);
   localparam logic signed [DW-1:0] GE_U_X   = DW'(GE_UNCAL);
   localparam logic signed [DW-1:0] OE_C_X   = DW'(OE_CAL);
   localparam logic signed [DW-1:0] OE_U_X   = DW'(OE_UNCAL);

   logic signed [DW-1:0] gmag;
   logic signed [DW-1:0] omag;

   always_comb begin
      gmag   = (rising_i ? GE_R_X : GE_F_X) + (cal_i ? '0 : GE_U_X);
      omag   = cal_i ? OE_C_X : OE_U_X;
      inl_o  = rising_i ? INL_X : -INL_X;
      gerr_o = rising_i ? gmag  : -gmag;
      oerr_o = rising_i ? omag  : -omag;
   end

endmodule

// File: rtl/thr_serial_div.sv
// Radix-2 restoring divider on magnitudes; quotient truncates toward zero.
module thr_serial_div #(
   parameter int DW = 48
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 go_i,
   input  logic signed [DW-1:0] num_i,
   input  logic signed [DW-1:0] den_i,
   output logic                 fin_o,
   output logic signed [DW-1:0] quo_o
);

   localparam int CW = $clog2(DW + 1);

   logic [DW-1:0] q_r;
   logic [DW-1:0] dmag_r;
   logic [DW:0]   rem_r;
   logic [CW-1:0] cnt_r;
   logic          neg_r;
   logic          fin_r;

   logic [DW-1:0] num_mag;
   logic [DW-1:0] den_mag;
   logic [DW:0]   shf;
   logic          fits;

   always_comb begin
      num_mag = num_i[DW-1] ? DW'(-num_i) : DW'(num_i);
      den_mag = den_i[DW-1] ? DW'(-den_i) : DW'(den_i);
      shf     = {rem_r[DW-1:0], q_r[DW-1]};
      fits    = (shf >= {1'b0, dmag_r});
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_r    <= '0;
         dmag_r <= '0;
         rem_r  <= '0;
         cnt_r  <= '0;
         neg_r  <= 1'b0;
         fin_r  <= 1'b0;
      end else if (go_i) begin
         q_r    <= num_mag;
         dmag_r <= den_mag;
         rem_r  <= '0;
         cnt_r  <= CW'(DW);
         neg_r  <= num_i[DW-1] ^ den_i[DW-1];
         fin_r  <= 1'b0;
      end else if (cnt_r != '0) begin
         rem_r  <= fits ? (shf - {1'b0, dmag_r}) : shf;
         q_r    <= {q_r[DW-2:0], fits};
         cnt_r  <= cnt_r - 1'b1;
         fin_r  <= (cnt_r == CW'(1));
      end else begin
         fin_r  <= 1'b0;
      end
   end

   assign fin_o = fin_r;
   assign quo_o = neg_r ? -$signed(q_r) : $signed(q_r);

endmodule

// File: rtl/thr_sat.sv
// Saturates a wide signed value into an unsigned code range.
module thr_sat #(
   parameter int DW     = 48,
   parameter int CODE_W = 12
) (
   input  logic signed [DW-1:0] val_i,
   output logic [CODE_W-1:0]    code_o
);

   localparam logic signed [DW-1:0] TOP_X = DW'((1 << CODE_W) - 1);

   always_comb begin
      if (val_i < 0)
         code_o = '0;
      else if (val_i > TOP_X)
         code_o = '1;
      else
         code_o = val_i[CODE_W-1:0];
   end

endmodule

// File: rtl/thr_code_gen.sv
module thr_code_gen
   import thr_code_pkg::*;
#(
   parameter int THR_W    = 16,
   parameter int GAIN_W   = 16,
   parameter int KERR_W   = 16,
   parameter int OFF_W    = 32,
   parameter int CODE_W   = 12,
   parameter int DW       = 48,
   parameter int INL_LSB  = 2,
   parameter int GE_RISE  = 2,
   parameter int GE_FALL  = 6,
   parameter int GE_UNCAL = 20,
   parameter int OE_CAL   = 2,
   parameter int OE_UNCAL = 36
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start_i,
   input  logic                     rising_i,
   input  logic                     calibrated_i,
   input  logic signed [THR_W-1:0]  thr_mv_i,
   input  logic signed [GAIN_W-1:0] gain_i,
   input  logic signed [KERR_W-1:0] kerr_i,
   input  logic signed [OFF_W-1:0]  offset_i,
   output logic                     done_o,
   output logic                     rejected_o,
   output logic [CODE_W-1:0]        code_o
);

   localparam logic signed [DW-1:0] SCALE_X  = DW'(PER_MILLE);
   localparam logic signed [DW-1:0] CODE_TOP = DW'((1 << CODE_W) - 1);
   // Headroom: base code ~ 2^(CODE_W+10), times correction 2^(KERR_W-1)
   localparam int NEED_W = CODE_W + 10 + KERR_W + 2;

   // Elaboration-time parameter checks
   if (DW < NEED_W) begin : g_err_dw_mul
      $error("thr_code_gen: DW too small for the trim product");
   end
   if (DW < OFF_W + 2) begin : g_err_dw_off
      $error("thr_code_gen: DW too small for the offset");
   end
   if (CODE_W > 24 || CODE_W < 4) begin : g_err_code
      $error("thr_code_gen: CODE_W out of supported range");
   end
   if (THR_W > DW - 12 || GAIN_W > DW) begin : g_err_in
      $error("thr_code_gen: input widths exceed the datapath");
   end

   thr_state_e           st_q;
   logic                 rise_q, cal_q;
   logic signed [DW-1:0] k_q, off_q;
   logic signed [DW-1:0] num_q, den_q;
   logic                 go_q;
   logic                 done_q, rej_q;
   logic [CODE_W-1:0]    code_q;

   logic                 fin;
   logic signed [DW-1:0] quo;
   logic signed [DW-1:0] inl, gerr, oerr;
   logic signed [DW-1:0] thr_x;
   logic                 in_bad;
   logic signed [DW-1:0] cal_num, tol_num, fin_val;
   logic [CODE_W-1:0]    sat_code;

   thr_tol_pick #(
      .DW(DW), .INL_LSB(INL_LSB), .GE_RISE(GE_RISE), .GE_FALL(GE_FALL),
      .GE_UNCAL(GE_UNCAL), .OE_CAL(OE_CAL), .OE_UNCAL(OE_UNCAL)
   ) u_tol (
      .rising_i (rise_q),
      .cal_i    (cal_q),
      .inl_o    (inl),
      .gerr_o   (gerr),
      .oerr_o   (oerr)
   );

   thr_serial_div #(.DW(DW)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .go_i  (go_q),
      .num_i (num_q),
      .den_i (den_q),
      .fin_o (fin),
      .quo_o (quo)
   );

   thr_sat #(.DW(DW), .CODE_W(CODE_W)) u_sat (
      .val_i  (fin_val),
      .code_o (sat_code)
   );

   always_comb begin
      thr_x   = DW'(thr_mv_i);
      in_bad  = (thr_x < 0) || (thr_x > CODE_TOP) || (gain_i <= 0);
      cal_num = quo * k_q + (rise_q ? off_q : -off_q);
      tol_num = (quo + inl) * (SCALE_X + gerr);
      fin_val = quo + oerr;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         rise_q <= 1'b0;
         cal_q  <= 1'b0;
         k_q    <= '0;
         off_q  <= '0;
         num_q  <= '0;
         den_q  <= '0;
         go_q   <= 1'b0;
         done_q <= 1'b0;
         rej_q  <= 1'b0;
         code_q <= '0;
      end else begin
         go_q   <= 1'b0;
         done_q <= 1'b0;
         case (st_q)
            ST_IDLE: begin
               if (start_i) begin
                  rise_q <= rising_i;
                  cal_q  <= calibrated_i;
                  k_q    <= DW'(kerr_i);
                  off_q  <= DW'(offset_i);
                  if (in_bad) begin
                     done_q <= 1'b1;
                     rej_q  <= 1'b1;
                  end else begin
                     num_q <= thr_x * SCALE_X;
                     den_q <= DW'(gain_i);
                     go_q  <= 1'b1;
                     st_q  <= ST_INV;
                  end
               end
            end
            ST_INV: begin
               if (fin) begin
                  go_q  <= 1'b1;
                  den_q <= SCALE_X;
                  if (cal_q) begin
                     num_q <= cal_num;
                     st_q  <= ST_CAL;
                  end else begin
                     num_q <= tol_num;
                     st_q  <= ST_TOL;
                  end
               end
            end
            ST_CAL: begin
               if (fin) begin
                  go_q  <= 1'b1;
                  den_q <= SCALE_X;
                  num_q <= tol_num;
                  st_q  <= ST_TOL;
               end
            end
            ST_TOL: begin
               if (fin) begin
                  code_q <= sat_code;
                  rej_q  <= 1'b0;
                  done_q <= 1'b1;
                  st_q   <= ST_IDLE;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign done_o     = done_q;
   assign rejected_o = rej_q;
   assign code_o     = code_q;

endmodule

// File: rtl/thr_code_gen_chk.sv
module thr_code_gen_chk #(
   parameter int THR_W  = 16,
   parameter int GAIN_W = 16,
   parameter int CODE_W = 12,
   parameter int DW     = 48
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     start_i,
   input logic signed [THR_W-1:0]  thr_mv_i,
   input logic signed [GAIN_W-1:0] gain_i,
   input logic                     done_o,
   input logic                     rejected_o,
   input logic [CODE_W-1:0]        code_o
);

   localparam int LAT_MAX = 3 * (DW + 2) + 2;
   localparam int LCW     = $clog2(LAT_MAX + 2) + 1;

   logic           busy_m;
   logic [LCW-1:0] lat_m;
   logic           acc;
   logic           bad;

   always_comb begin
      acc = start_i && (!busy_m || done_o);
      bad = (int'(thr_mv_i) < 0) || (int'(thr_mv_i) > ((1 << CODE_W) - 1))
            || (int'(gain_i) <= 0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_m <= 1'b0;
         lat_m  <= '0;
      end else begin
         busy_m <= (busy_m && !done_o) || start_i;
         if (acc)
            lat_m <= '0;
         else if (busy_m && !done_o && lat_m != '1)
            lat_m <= lat_m + 1'b1;
      end
   end

   AST_REJECT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      acc && bad |=> done_o && rejected_o);                           // R9

   AST_REJECT_KEEPS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && rejected_o |-> $stable(code_o));                      // R9

   AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(code_o) && $stable(rejected_o));            // R10

   AST_DONE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> busy_m);                                             // R10

   AST_LATENCY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      busy_m && !done_o |-> lat_m <= LCW'(LAT_MAX));                  // R10

   AST_VALID_NOT_INSTANT: assert property (@(posedge clk) disable iff (!rst_n)
      acc && !bad |=> !done_o);                                       // R10

   AST_VALID_CLEARS_REJ: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && !$past(acc) |-> !rejected_o);                         // R10

endmodule

bind thr_code_gen thr_code_gen_chk #(
   .THR_W(THR_W), .GAIN_W(GAIN_W), .CODE_W(CODE_W), .DW(DW)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .thr_mv_i   (thr_mv_i),
   .gain_i     (gain_i),
   .done_o     (done_o),
   .rejected_o (rejected_o),
   .code_o     (code_o)
);

// File: tb/thr_code_gen_tb.sv
module thr_code_gen_tb;

   localparam int CLK_PERIOD = 10;
   localparam int LAT_MAX    = 3 * (48 + 2) + 2;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               start_i = 1'b0;
   logic               rising_i = 1'b0;
   logic               calibrated_i = 1'b0;
   logic signed [15:0] thr_mv_i = '0;
   logic signed [15:0] gain_i = '0;
   logic signed [15:0] kerr_i = '0;
   logic signed [31:0] offset_i = '0;
   logic               done_o;
   logic               rejected_o;
   logic [11:0]        code_o;

   int checks = 0;
   int errors = 0;

   int    exp_code[$];
   bit    exp_rej[$];
   string exp_tag[$];
   int    held_code = 0;
   bit    held_rej  = 1'b0;
   int    model_code = 0;
   bit    monitor_on = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   thr_code_gen u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .rising_i     (rising_i),
      .calibrated_i (calibrated_i),
      .thr_mv_i     (thr_mv_i),
      .gain_i       (gain_i),
      .kerr_i       (kerr_i),
      .offset_i     (offset_i),
      .done_o       (done_o),
      .rejected_o   (rejected_o),
      .code_o       (code_o)
   );

   // Behavioural reference: R2..R8 in 64-bit integer arithmetic
   function automatic int ref_code(longint thr, longint gain, longint k,
                                   longint off, bit rise, bit cal);
      longint c, inl, ge, oe, v;
      c = (thr * 1000) / gain;
      if (cal) c = (c * k + (rise ? off : -off)) / 1000;
      inl = rise ? 2 : -2;
      ge  = rise ? (cal ? 2 : 22) : (cal ? -6 : -26);
      oe  = rise ? (cal ? 2 : 36) : (cal ? -2 : -36);
      v   = ((c + inl) * (1000 + ge)) / 1000 + oe;
      if (v < 0) v = 0;
      if (v > 4095) v = 4095;
      return int'(v);
   endfunction

   // Per-clock comparison against the model
   always @(negedge clk) begin
      if (monitor_on) begin
         checks++;
         if (done_o) begin
            if (exp_code.size() == 0) begin
               errors++;
               $display("FAIL R10 R11: unexpected done, code %0d expected no done",
                        code_o);
            end else begin
               if (int'(code_o) != exp_code[0] || rejected_o != exp_rej[0]) begin
                  errors++;
                  $display("FAIL %s: code %0d rej %0d expected code %0d rej %0d",
                           exp_tag[0], code_o, rejected_o, exp_code[0], exp_rej[0]);
               end
               held_code = exp_code[0];
               held_rej  = exp_rej[0];
               void'(exp_code.pop_front());
               void'(exp_rej.pop_front());
               void'(exp_tag.pop_front());
            end
         end else if (int'(code_o) != held_code || rejected_o != held_rej) begin
            errors++;
            $display("FAIL R10: held code %0d rej %0d expected code %0d rej %0d",
                     code_o, rejected_o, held_code, held_rej);
         end
      end
   end

   task automatic issue(input int thr, input int gain, input int k, input int off,
                        input bit rise, input bit cal, input string tag,
                        input bit expect_taken);
      @(negedge clk);
      thr_mv_i     = 16'(thr);
      gain_i       = 16'(gain);
      kerr_i       = 16'(k);
      offset_i     = off;
      rising_i     = rise;
      calibrated_i = cal;
      start_i      = 1'b1;
      if (expect_taken) begin
         if (thr < 0 || thr > 4095 || gain <= 0) begin
            exp_code.push_back(model_code);
            exp_rej.push_back(1'b1);
         end else begin
            model_code = ref_code(thr, gain, k, off, rise, cal);
            exp_code.push_back(model_code);
            exp_rej.push_back(1'b0);
         end
         exp_tag.push_back(tag);
      end
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic drain();
      while (exp_code.size() != 0) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   task automatic run(input int thr, input int gain, input int k, input int off,
                      input bit rise, input bit cal, input string tag);
      issue(thr, gain, k, off, rise, cal, tag, 1'b1);
      drain();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset values
      checks++;
      if (code_o != 12'd0 || done_o || rejected_o) begin
         errors++;
         $display("FAIL R1: code %0d done %0d rej %0d expected 0 0 0",
                  code_o, done_o, rejected_o);
      end
      monitor_on = 1'b1;

      run(1000, 305, 1012, 12000, 1'b1, 1'b1, "R2 R3 R4 cal rising");
      run(900, 305, 998, -3000, 1'b0, 1'b1, "R3 R5 cal falling");
      run(600, 610, 1000, 0, 1'b1, 1'b0, "R6 uncal rising");
      run(600, 610, 1000, 0, 1'b0, 1'b0, "R6 uncal falling");
      run(2500, 1222, 1005, 4000, 1'b1, 1'b1, "R2 R4 second rising point");
      run(0, 305, 1000, -1500, 1'b1, 1'b1, "R7 truncation toward zero");
      run(1, 1000, 1000, 0, 1'b0, 1'b0, "R7 R8 negative quotient low clamp");
      run(4095, 1, 1000, 0, 1'b1, 1'b0, "R8 high saturation");
      run(0, 305, 1000, 5000, 1'b0, 1'b1, "R8 low saturation");
      run(3000, 900, 1010, 2000, 1'b1, 1'b1, "R4 before reject");
      run(4096, 305, 1000, 0, 1'b1, 1'b1, "R9 threshold above range");
      run(-1, 305, 1000, 0, 1'b0, 1'b1, "R9 negative threshold");
      run(1200, 0, 1000, 0, 1'b1, 1'b0, "R9 zero gain");
      run(1200, -50, 1000, 0, 1'b0, 1'b0, "R9 negative gain");
      run(1500, 400, 1000, 0, 1'b0, 1'b0, "R10 valid after reject clears flag");

      // R11: second start during computation must be ignored
      issue(2000, 500, 1003, 1000, 1'b1, 1'b1, "R11 first request wins", 1'b1);
      repeat (5) @(negedge clk);
      issue(300, 250, 990, -7000, 1'b0, 1'b0, "R11 ignored", 1'b0);
      repeat (20) @(negedge clk);
      issue(5000, 500, 1000, 0, 1'b1, 1'b1, "R11 ignored bad", 1'b0);
      drain();
      repeat (LAT_MAX + 10) @(negedge clk);

      // R10: completion within the latency bound
      issue(3333, 700, 1001, 500, 1'b0, 1'b1, "R10 latency", 1'b1);
      begin
         int waited;
         waited = 0;
         while (exp_code.size() != 0 && waited <= LAT_MAX + 2) begin
            @(negedge clk);
            waited++;
         end
         checks++;
         if (waited > LAT_MAX + 1) begin
            errors++;
            $display("FAIL R10: waited %0d cycles expected at most %0d",
                     waited, LAT_MAX + 1);
         end
      end
      drain();

      monitor_on = 1'b0;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule